// File: doc/BRIEF.md
# Error-Tagged Serial Receive Word Path

This block is the receive half of one asynchronous serial channel. It watches a serial input line, samples it under a 16x oversample tick supplied from outside, and rebuilds characters of 5 to 8 data bits. Each character may carry a parity bit, which is checked as even, odd, or forced mark/space (stick) parity. The frame ends with one or two stop bits. Every finished character goes into a 512-entry receive FIFO as a 12-bit word. The low byte holds the data. The upper four bits carry that character's own error tags: parity, overrun, framing and break.

Software-side logic drains the FIFO through a simple read port. The head word is visible whenever the FIFO holds data, and a one-cycle read strobe removes it. A 16-bit fill count reports how many words are waiting. A threshold interrupt rises when the fill count reaches a selectable level of 1, 256 or 448 entries. A flush control empties the FIFO. A receive-enable input stops reception altogether. The baud tick source and the host bus lie outside the block.

Top module: `serial_rx_tagged`

## Requirements
- R1: The stored word holds data in bits 7:0, right-justified, with unused upper data bits zero. The parity error flag is bit 8, overrun is bit 9, framing error is bit 10 and break is bit 11. `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data is received least significant bit first.
- R2: A falling edge on the line starts a frame only if the line is still low at the 8th oversample tick of the start bit. A shorter low pulse returns the receiver to idle and stores nothing.
- R3: With `par_en` = 1, a parity bit follows the data. `par_not_odd` = 0 selects odd parity and `par_not_odd` = 1 selects even parity. A mismatch sets bit 8. With `par_en` = 0, no parity bit is received and bit 8 is 0.
- R4: With `par_en` = 1 and `par_stick` = 1, the expected parity bit is 1 (mark) when `par_not_odd` = 0 and 0 (space) when `par_not_odd` = 1. Any other received value sets bit 8.
- R5: `two_stop` = 1 makes the receiver sample two stop bits. If any sampled stop bit is low, the word gets the framing flag (bit 10) and keeps its data.
- R6: A frame whose data bits, parity bit (if enabled) and first stop bit are all low is a break. It is stored as exactly one word of value 0xC00, and the receiver then waits for the line to return high before it looks for a new start bit.
- R7: The FIFO keeps words in arrival order and holds up to 512 of them. `rd_valid` is 1 while it is not empty. `rd_word` shows the oldest word, and `rd_en` removes it. `rd_en` while empty has no effect.
- R8: A character that completes while the FIFO holds 512 words is dropped. The next word that is stored carries the overrun flag (bit 9).
- R9: `fill_count` equals the number of stored words. It changes on the clock edge that performs a push or a pop, and a push and a pop in the same cycle leave it unchanged.
- R10: `thresh_irq` is 1 when `fill_count` is at or above the level chosen by `trig_sel`: 1 gives 1, 2 gives 256 and 3 gives 448. `trig_sel` = 0 keeps it at 0.
- R11: A cycle with `flush` high empties the FIFO, drops any character completing in that cycle, and clears a pending overrun mark.
- R12: While `rx_enable` is 0, the receiver stays idle, abandons any frame in progress and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_enable | input | 1 | Reception enable |
| len_sel | input | 2 | Data length: 0..3 means 5..8 bits |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Parity bit present and checked |
| par_not_odd | input | 1 | 0 selects odd, 1 selects even (space when stick) |
| par_stick | input | 1 | Forces mark or space parity |
| trig_sel | input | 2 | Interrupt level: 0 off, 1, 256, 448 entries |
| flush | input | 1 | Empties the FIFO |
| rd_en | input | 1 | Pops the head word |
| rd_word | output | 12 | Head word: tags in 11:8, data in 7:0 |
| rd_valid | output | 1 | FIFO not empty |
| fill_count | output | 16 | Number of stored words |
| thresh_irq | output | 1 | Fill count at or above the selected level |

## Verification
The line passes through a two-flop synchronizer, so a decision is taken two clocks after the line changes, on an oversample tick. A word is written one clock after the tick that samples the last stop bit, and `fill_count`, `rd_valid` and `thresh_irq` follow on the next edge. The bench therefore checks stored words only after a full idle bit time of 16 ticks has followed the frame, which is far beyond that three-clock latency. Reads and flushes are driven on a falling edge and checked on the next falling edge, one clock after the edge that acts on them. Threshold checks change `trig_sel` and sample the combinational interrupt one nanosecond later.

// File: rtl/srx_pkg.sv
// Shared types for the tagged serial receive path.
// Assumes: the word layout is fixed by software that decodes the tag bits.
package srx_pkg;

    // Stored character: tags above the right-justified data byte.
    typedef struct packed {
        logic       brk;   // bit 11
        logic       frm;   // bit 10
        logic       ovr;   // bit 9
        logic       par;   // bit 8
        logic [7:0] data;  // bits 7:0
    } rx_word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP1,
        S_STOP2,
        S_HOLD
    } rx_state_e;

endpackage

// File: rtl/srx_deframer.sv
// Bit-level receiver: synchronises the line, validates the start bit at its
// middle, gathers 5..8 data bits LSB first, an optional parity bit and one or
// two stop bits, then emits one tagged word for one cycle.
// Assumes: os_tick is a single-cycle pulse at OSR times the bit rate and the
// frame configuration is held steady while a frame is in flight.
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       os_tick,
    input  logic       rx_async,
    input  logic [1:0] len_sel,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic       par_not_odd,
    input  logic       par_stick,
    output logic       word_valid,
    output rx_word_t   word_out
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_T  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);

    logic          sync1, rx;
    rx_state_e     state;
    logic [CW-1:0] tick_cnt;
    logic [3:0]    bit_idx;
    logic [7:0]    shreg;
    logic          par_bit;
    logic          stop1_zero_q;
    logic          stop2_bad;
    rx_word_t      word_q;

    logic [3:0]    nbits;
    logic [7:0]    data_rj;
    logic          exp_par;
    logic          s1_zero;
    logic          any_stop_bad;
    logic          at_end;
    rx_word_t      word_next;

    // Decode the frame shape and assemble the word that a final stop sample would emit.
    always_comb begin
        nbits        = 4'd5 + {2'b00, len_sel};
        data_rj      = shreg >> (4'd8 - nbits);
        exp_par      = par_stick ? ~par_not_odd
                                 : (par_not_odd ? ^data_rj : ~^data_rj);
        s1_zero      = (state == S_STOP1) ? ~rx : stop1_zero_q;
        stop2_bad    = (state == S_STOP2) & ~rx;
        any_stop_bad = s1_zero | stop2_bad;
        at_end       = (tick_cnt == LAST_T);
        word_next.data = data_rj;
        word_next.brk  = (data_rj == 8'h00) & (~par_en | ~par_bit) & s1_zero;
        word_next.frm  = any_stop_bad;
        word_next.ovr  = 1'b0;
        word_next.par  = par_en & (par_bit != exp_par) & ~word_next.brk;
    end

    // Line synchroniser, frame state machine and output word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1        <= 1'b1;
            rx           <= 1'b1;
            state        <= S_IDLE;
            tick_cnt     <= '0;
            bit_idx      <= '0;
            shreg        <= '0;
            par_bit      <= 1'b0;
            stop1_zero_q <= 1'b0;
            word_valid   <= 1'b0;
            word_q       <= '0;
        end else begin
            sync1      <= rx_async;
            rx         <= sync1;
            word_valid <= 1'b0;
            if (!enable) begin
                state <= S_IDLE;
            end else if (os_tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rx) begin
                            state    <= S_START;
                            tick_cnt <= '0;
                        end
                    end
                    S_START: begin
                        if (tick_cnt == MID_T) begin
                            tick_cnt <= '0;
                            if (rx) begin
                                state <= S_IDLE;
                            end else begin
                                state        <= S_DATA;
                                bit_idx      <= '0;
                                shreg        <= '0;
                                par_bit      <= 1'b0;
                                stop1_zero_q <= 1'b0;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_end) begin
                            shreg   <= {rx, shreg[7:1]};
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == nbits - 4'd1)
                                state <= par_en ? S_PAR : S_STOP1;
                        end
                    end
                    S_PAR: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_end) begin
                            par_bit <= rx;
                            state   <= S_STOP1;
                        end
                    end
                    S_STOP1, S_STOP2: begin
                        tick_cnt <= tick_cnt + 1'b1;
                        if (at_end) begin
                            if (state == S_STOP1 && two_stop) begin
                                stop1_zero_q <= ~rx;
                                state        <= S_STOP2;
                            end else begin
                                word_valid <= 1'b1;
                                word_q     <= word_next;
                                state      <= rx ? S_IDLE : S_HOLD;
                            end
                        end
                    end
                    S_HOLD: begin
                        if (rx) state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign word_out = word_q;

    // R6: a break word always carries framing, zero data and no parity tag.
    a_r6_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_out.brk) |-> (word_out.frm && word_out.data == 8'h00 && !word_out.par));

    // R12: no word leaves the receiver in the cycle after it was disabled.
    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !word_valid);

endmodule

// File: rtl/srx_word_fifo.sv
// Receive word store: circular buffer of DEPTH tagged words with a fill count.
// A word arriving while full is dropped and marks the next stored word with
// the overrun tag. Flush empties the store and clears that mark.
// Assumes: the consumer reads the head combinationally and pops with pop_req.
module srx_word_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  rx_word_t      push_data,
    input  logic          pop_req,
    output rx_word_t      head,
    output logic          not_empty,
    output logic [CW-1:0] count_o
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_N  = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);

    rx_word_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          ovr_pend;
    logic          push_ok, pop_ok;
    rx_word_t      wdata;

    // Accept and release decisions plus the overrun tag merge.
    always_comb begin
        push_ok    = push && (cnt != FULL_N) && !flush;
        pop_ok     = pop_req && (cnt != '0) && !flush;
        wdata      = push_data;
        wdata.ovr  = push_data.ovr | ovr_pend;
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointers, occupancy and the pending overrun mark.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr   <= (wr_ptr == LAST_IX) ? '0 : wr_ptr + 1'b1;
                ovr_pend <= 1'b0;
            end else if (push && cnt == FULL_N) begin
                ovr_pend <= 1'b1;
            end
            if (pop_ok) rd_ptr <= (rd_ptr == LAST_IX) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
        end
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (cnt != '0);
    assign count_o   = CW'(cnt);

    // R11: one flush cycle leaves the store empty.
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

    // R8: a full store without a pop or flush stays full whatever arrives.
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_N && !pop_req && !flush) |=> (cnt == FULL_N));

    // R7: a pop request on an empty store changes nothing.
    a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !push) |=> (cnt == '0));

endmodule

// File: rtl/srx_level_irq.sv
// Threshold interrupt: compares the fill count with the level picked by a
// 2-bit select (0 off, then three fixed levels).
// Assumes: the count input is the registered occupancy, so the output is glitch-free per cycle.
module srx_level_irq #(
    parameter int CW   = 16,
    parameter int LVL1 = 1,
    parameter int LVL2 = 256,
    parameter int LVL3 = 448
) (
    input  logic [CW-1:0] level_cnt,
    input  logic [1:0]    trig_sel,
    output logic          irq
);

    // Level selection and comparison.
    always_comb begin
        case (trig_sel)
            2'd1:    irq = (level_cnt >= CW'(LVL1));
            2'd2:    irq = (level_cnt >= CW'(LVL2));
            2'd3:    irq = (level_cnt >= CW'(LVL3));
            default: irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_rx_tagged.sv
// Top of the tagged serial receive path: receiver, word store and threshold
// interrupt. The head word is presented as a plain 12-bit vector.
// Assumes: os_tick comes from an external baud generator in this clock domain.
module serial_rx_tagged
    import srx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 512,
    parameter int CNT_W = 16,
    parameter int LVL1  = 1,
    parameter int LVL2  = 256,
    parameter int LVL3  = 448
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_serial,
    input  logic             os_tick,
    input  logic             rx_enable,
    input  logic [1:0]       len_sel,
    input  logic             two_stop,
    input  logic             par_en,
    input  logic             par_not_odd,
    input  logic             par_stick,
    input  logic [1:0]       trig_sel,
    input  logic             flush,
    input  logic             rd_en,
    output logic [11:0]      rd_word,
    output logic             rd_valid,
    output logic [CNT_W-1:0] fill_count,
    output logic             thresh_irq
);

    rx_word_t fr_word;
    logic     fr_valid;
    rx_word_t head;

    srx_deframer #(.OSR(OSR)) u_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (rx_enable),
        .os_tick     (os_tick),
        .rx_async    (rx_serial),
        .len_sel     (len_sel),
        .two_stop    (two_stop),
        .par_en      (par_en),
        .par_not_odd (par_not_odd),
        .par_stick   (par_stick),
        .word_valid  (fr_valid),
        .word_out    (fr_word)
    );

    srx_word_fifo #(.DEPTH(DEPTH), .CW(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (fr_valid),
        .push_data (fr_word),
        .pop_req   (rd_en),
        .head      (head),
        .not_empty (rd_valid),
        .count_o   (fill_count)
    );

    srx_level_irq #(.CW(CNT_W), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_irq (
        .level_cnt (fill_count),
        .trig_sel  (trig_sel),
        .irq       (thresh_irq)
    );

    assign rd_word = rd_valid ? head : 12'h000;

    // R10: the interrupt never asks for service when nothing is stored.
    a_r10_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_irq |-> (fill_count != '0));

endmodule

// File: tb/serial_rx_tagged_test.sv
module serial_rx_tagged_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_serial = 1'b1;
    logic        os_tick = 1'b0;
    logic        rx_enable = 1'b1;
    logic [1:0]  len_sel = 2'd3;
    logic        two_stop = 1'b0;
    logic        par_en = 1'b0;
    logic        par_not_odd = 1'b0;
    logic        par_stick = 1'b0;
    logic [1:0]  trig_sel = 2'd1;
    logic        flush = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_word;
    logic        rd_valid;
    logic [15:0] fill_count;
    logic        thresh_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 2;
    int div_cnt = 0;

    serial_rx_tagged uut (
        .clk (clk), .rst_n (rst_n), .rx_serial (rx_serial), .os_tick (os_tick),
        .rx_enable (rx_enable), .len_sel (len_sel), .two_stop (two_stop),
        .par_en (par_en), .par_not_odd (par_not_odd), .par_stick (par_stick),
        .trig_sel (trig_sel), .flush (flush), .rd_en (rd_en), .rd_word (rd_word),
        .rd_valid (rd_valid), .fill_count (fill_count), .thresh_irq (thresh_irq)
    );

    always #5 clk = ~clk;

    // Oversample tick source, changed away from the active edge.
    always @(negedge clk) begin
        if (div_cnt >= tick_div - 1) begin
            div_cnt = 0;
            os_tick = 1'b1;
        end else begin
            div_cnt = div_cnt + 1;
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (os_tick !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rx_serial = v;
        wait_ticks(16);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int n,
                                     input logic not_odd, input logic stick);
        logic [7:0] m;
        m = d & ((8'd1 << n) - 8'd1);
        if (stick) return ~not_odd;
        return not_odd ? ^m : ~^m;
    endfunction

    task automatic send_frame(input logic [7:0] d, input int n, input bit pe,
                              input logic pv, input int ns, input logic s1,
                              input logic s2, input int idle_bits);
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(d[i]);
        if (pe) send_bit(pv);
        send_bit(s1);
        if (ns == 2) send_bit(s2);
        for (int i = 0; i < idle_bits; i++) send_bit(1'b1);
    endtask

    task automatic cfg(input logic [1:0] len, input logic two, input logic pe,
                       input logic pno, input logic stick);
        @(negedge clk);
        len_sel = len; two_stop = two; par_en = pe; par_not_odd = pno; par_stick = stick;
    endtask

    task automatic check_pop(input string tag, input int exp);
        @(negedge clk);
        chk({tag, " valid"}, int'(rd_valid), 1);
        chk({tag, " word"}, int'(rd_word), exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 reset count", int'(fill_count), 0);
        chk("R7 reset valid", int'(rd_valid), 0);
        chk("R10 reset irq", int'(thresh_irq), 0);
    endtask

    task automatic t_lengths();
        cfg(2'd3, 0, 0, 0, 0);
        send_frame(8'hA5, 8, 0, 0, 1, 1, 1, 2);
        check_pop("R1 8-bit", 12'h0A5);
        cfg(2'd0, 0, 0, 0, 0);
        send_frame(8'hF5, 5, 0, 0, 1, 1, 1, 2);
        check_pop("R1 5-bit", 12'h015);
        cfg(2'd1, 0, 0, 0, 0);
        send_frame(8'hEC, 6, 0, 0, 1, 1, 1, 2);
        check_pop("R1 6-bit", 12'h02C);
        cfg(2'd2, 0, 0, 0, 0);
        send_frame(8'hDA, 7, 0, 0, 1, 1, 1, 2);
        check_pop("R1 7-bit", 12'h05A);
    endtask

    task automatic t_false_start();
        cfg(2'd3, 0, 0, 0, 0);
        @(negedge clk);
        rx_serial = 1'b0;
        wait_ticks(4);
        @(negedge clk);
        rx_serial = 1'b1;
        wait_ticks(48);
        @(negedge clk);
        chk("R2 false start count", int'(fill_count), 0);
        send_frame(8'h3C, 8, 0, 0, 1, 1, 1, 2);
        check_pop("R2 frame after glitch", 12'h03C);
    endtask

    task automatic t_parity();
        logic p;
        cfg(2'd2, 0, 1, 1, 0);
        p = exp_par(8'h53, 7, 1, 0);
        send_frame(8'h53, 7, 1, p, 1, 1, 1, 2);
        check_pop("R3 even good", 12'h053);
        send_frame(8'h53, 7, 1, ~p, 1, 1, 1, 2);
        check_pop("R3 even bad", 12'h153);
        cfg(2'd2, 0, 1, 0, 0);
        p = exp_par(8'h53, 7, 0, 0);
        send_frame(8'h53, 7, 1, p, 1, 1, 1, 2);
        check_pop("R3 odd good", 12'h053);
        send_frame(8'h53, 7, 1, ~p, 1, 1, 1, 2);
        check_pop("R3 odd bad", 12'h153);
    endtask

    task automatic t_stick();
        cfg(2'd3, 0, 1, 0, 1);
        send_frame(8'h81, 8, 1, 1'b1, 1, 1, 1, 2);
        check_pop("R4 mark good", 12'h081);
        send_frame(8'h81, 8, 1, 1'b0, 1, 1, 1, 2);
        check_pop("R4 mark bad", 12'h181);
        cfg(2'd3, 0, 1, 1, 1);
        send_frame(8'h81, 8, 1, 1'b0, 1, 1, 1, 2);
        check_pop("R4 space good", 12'h081);
        send_frame(8'h81, 8, 1, 1'b1, 1, 1, 1, 2);
        check_pop("R4 space bad", 12'h181);
    endtask

    task automatic t_stop();
        cfg(2'd3, 0, 0, 0, 0);
        send_frame(8'h3C, 8, 0, 0, 1, 0, 1, 2);
        check_pop("R5 one stop low", 12'h43C);
        cfg(2'd3, 1, 0, 0, 0);
        send_frame(8'h3C, 8, 0, 0, 2, 1, 1, 2);
        check_pop("R5 two stops good", 12'h03C);
        send_frame(8'h3C, 8, 0, 0, 2, 1, 0, 2);
        check_pop("R5 second stop low", 12'h43C);
    endtask

    task automatic t_break();
        cfg(2'd3, 0, 0, 0, 0);
        @(negedge clk);
        rx_serial = 1'b0;
        wait_ticks(16 * 22);
        send_bit(1'b1);
        send_bit(1'b1);
        @(negedge clk);
        chk("R6 break single entry", int'(fill_count), 1);
        check_pop("R6 break word", 12'hC00);
        cfg(2'd3, 0, 1, 0, 0);
        @(negedge clk);
        rx_serial = 1'b0;
        wait_ticks(16 * 16);
        send_bit(1'b1);
        send_bit(1'b1);
        check_pop("R6 break with parity", 12'hC00);
    endtask

    task automatic t_enable();
        cfg(2'd3, 0, 0, 0, 0);
        @(negedge clk);
        rx_enable = 1'b0;
        send_frame(8'h77, 8, 0, 0, 1, 1, 1, 2);
        @(negedge clk);
        chk("R12 disabled count", int'(fill_count), 0);
        rx_enable = 1'b1;
        send_frame(8'h66, 8, 0, 0, 1, 1, 1, 2);
        check_pop("R12 re-enabled", 12'h066);
    endtask

    task automatic t_flush();
        cfg(2'd3, 0, 0, 0, 0);
        send_frame(8'h11, 8, 0, 0, 1, 1, 1, 1);
        send_frame(8'h22, 8, 0, 0, 1, 1, 1, 1);
        send_frame(8'h33, 8, 0, 0, 1, 1, 1, 1);
        @(negedge clk);
        chk("R9 three stored", int'(fill_count), 3);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R11 flush count", int'(fill_count), 0);
        chk("R11 flush valid", int'(rd_valid), 0);
    endtask

    task automatic irq_at(input logic [1:0] ts, input int exp, input string tag);
        @(negedge clk);
        trig_sel = ts;
        #1;
        chk(tag, int'(thresh_irq), exp);
    endtask

    task automatic t_fill();
        tick_div = 1;
        cfg(2'd0, 0, 0, 0, 0);
        for (int i = 0; i < 512; i++) begin
            send_frame(8'(i), 5, 0, 0, 1, 1, 1, 1);
            if (i + 1 == 1) begin
                irq_at(2'd1, 1, "R10 level 1 reached");
                irq_at(2'd2, 0, "R10 level 256 not reached");
                irq_at(2'd0, 0, "R10 off");
            end
            if (i + 1 == 255) irq_at(2'd2, 0, "R10 at 255");
            if (i + 1 == 256) begin
                irq_at(2'd2, 1, "R10 at 256");
                irq_at(2'd3, 0, "R10 448 at 256");
            end
            if (i + 1 == 447) irq_at(2'd3, 0, "R10 at 447");
            if (i + 1 == 448) begin
                irq_at(2'd3, 1, "R10 at 448");
                irq_at(2'd0, 0, "R10 off while busy");
            end
        end
        @(negedge clk);
        chk("R7 full count", int'(fill_count), 512);
        send_frame(8'h1F, 5, 0, 0, 1, 1, 1, 1);
        @(negedge clk);
        chk("R8 dropped while full", int'(fill_count), 512);
        check_pop("R7 oldest first", 12'h000);
        chk("R9 after pop", int'(fill_count), 511);
        send_frame(8'h0A, 5, 0, 0, 1, 1, 1, 1);
        @(negedge clk);
        chk("R9 refilled", int'(fill_count), 512);
        for (int j = 1; j < 512; j++) check_pop("R7 order", j % 32);
        check_pop("R8 overrun tag", 12'h20A);
        @(negedge clk);
        chk("R9 drained", int'(fill_count), 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7 pop empty count", int'(fill_count), 0);
        chk("R7 pop empty valid", int'(rd_valid), 0);
        tick_div = 2;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_false_start();
        t_parity();
        t_stick();
        t_stop();
        t_break();
        t_enable();
        t_flush();
        t_fill();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule